// File: doc/BRIEF.md
# Exception Entry and Fault Recording Unit

This unit sits between the pipeline's exception arbitration and the privileged control registers. When the pipeline presents a pending exception, interrupt, reset or address-translation fault together with a valid strobe, the unit computes in one step every register change that exception entry requires, and the return address that goes with it. It works out the return PC, stepping back one instruction when the faulting instruction sat in a branch delay slot. It sets the status bits that enter the error or exception level and it derives the cause code. For translation faults it also captures the faulting virtual address in the three address-recording registers. It then produces the new fetch address.

The register file keeps the current Status, Cause, Context, EBase and EntryHi values and feeds them in. The unit registers the updated values, together with write flags, for one commit cycle. The fetch unit takes the redirect PC on the same cycle. Translation faults are classified from a two-bit fault code plus a store flag. Every other general exception supplies its own 5-bit code.

Top module: `exc_entry`

## Requirements
- R1: Translation faults (kind 4) get their cause code from the fault code and the store flag. Fault code 0 (bad address) gives 4 on a load and 5 on a store. Codes 1 (no match) and 2 (invalid entry) give 2 on a load and 3 on a store. Code 3 (write to a clean page) gives 1. An interrupt (kind 3) gives code 0. A generic exception (kind 5) uses `exc_code_in`.
- R2: On a translation fault, `badvaddr_q` takes the faulting address and `fault_wr` pulses. Any other kind leaves `badvaddr_q`, `context_q` and `entryhi_q` unchanged and `fault_wr` low.
- R3: On a translation fault, `context_q` bits 22:4 take address bits 31:13. All other bits come from `context_in`.
- R4: On a translation fault, `entryhi_q` is the address with bits 12:0 cleared, ORed with the 8-bit ASID `entryhi_in[7:0]`.
- R5: For a general exception (kinds 3, 4 and 5) with Status.EXL (bit 1) clear, `epc_q` becomes PC−4 and Cause.BD (bit 31) is set when `in_delay_slot` is high. Otherwise `epc_q` becomes PC and BD is cleared. `epc_wr` pulses. With EXL set, `epc_q` and BD keep their previous values and `epc_wr` stays low.
- R6: A general exception sets Status.EXL and clears the mode bits Status[4:3]. All other Status bits pass through.
- R7: The general vector base is 0xBFC00200 when Status.BEV (bit 22) is set, and otherwise `ebase_in` with bits 9:0 cleared.
- R8: The offset added to the base is 0x000 only for a no-match translation fault taken with EXL clear. It is 0x200 for an interrupt when Cause.IV (bit 23) is set, and 0x180 in every other case.
- R9: A general exception writes its 5-bit code into Cause bits 6:2. The other Cause bits, apart from BD, pass through from `cause_in`.
- R10: Hard reset (kind 0), soft reset (kind 1) and NMI (kind 2) set Status.ERL (bit 2) and BEV. They write PC, or PC−4 from a delay slot, into `errorepc_q` with an `errorepc_wr` pulse, and redirect to 0xBFC00000. They clear Cause.BD only when EXL is clear, and leave the Cause code unchanged.
- R11: Soft reset also sets Status.SR (bit 20), and NMI also sets Status.NMI (bit 19). Hard reset sets neither.
- R12: Every update commits in the cycle after the strobe, together with a one-cycle `redirect_vld` pulse. With no strobe, all register outputs hold and all pulse outputs stay low.
- R13: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_valid | input | 1 | Exception strobe |
| exc_kind | input | 3 | 0 hard reset, 1 soft reset, 2 NMI, 3 interrupt, 4 translation fault, 5 generic |
| exc_code_in | input | 5 | Cause code for generic exceptions |
| xlat_fault | input | 2 | 0 bad address, 1 no match, 2 invalid, 3 clean page written |
| xlat_store | input | 1 | Faulting access was a store |
| in_delay_slot | input | 1 | Excepting instruction is in a delay slot |
| cur_pc | input | 32 | PC of the excepting instruction |
| fault_addr | input | 32 | Faulting virtual address |
| status_in | input | 32 | Current Status |
| cause_in | input | 32 | Current Cause |
| context_in | input | 32 | Current Context |
| ebase_in | input | 32 | Current EBase |
| entryhi_in | input | 32 | Current EntryHi |
| redirect_vld | output | 1 | Commit pulse for redirect and register writes |
| redirect_pc | output | 32 | New fetch address |
| status_q | output | 32 | Updated Status |
| cause_q | output | 32 | Updated Cause |
| epc_q | output | 32 | Exception return PC |
| epc_wr | output | 1 | `epc_q` is written this commit |
| errorepc_q | output | 32 | Error return PC |
| errorepc_wr | output | 1 | `errorepc_q` is written this commit |
| badvaddr_q | output | 32 | Faulting address |
| context_q | output | 32 | Updated Context |
| entryhi_q | output | 32 | Updated EntryHi |
| fault_wr | output | 1 | The three address registers are written this commit |

## Verification
The unit holds little state beyond its output registers, so a wrong classification or a wrong stored value shows at the ports on the first commit cycle after the strobe. A wrong cause code, offset or return PC appears directly in `cause_q`, `redirect_pc` or `epc_q`. A hold path that fails, or a pulse that sticks, shows on the next idle cycle as a changed register value or an extra commit. The bench therefore checks every output on every cycle, covering both commit cycles and idle cycles. Random stimulus is weighted so that EXL, BEV, IV and the delay-slot flag all toggle often.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [2:0] {
    EK_HRST = 3'd0,
    EK_SRST = 3'd1,
    EK_NMI  = 3'd2,
    EK_INT  = 3'd3,
    EK_XLAT = 3'd4,
    EK_GEN  = 3'd5
  } exc_kind_e;

  typedef enum logic [1:0] {
    XF_BADADDR = 2'd0,
    XF_NOMATCH = 2'd1,
    XF_INVALID = 2'd2,
    XF_DIRTY   = 2'd3
  } xlat_fault_e;

  typedef enum logic [1:0] {
    OFF_REFILL  = 2'd0,
    OFF_GENERAL = 2'd1,
    OFF_IRQ     = 2'd2
  } off_sel_e;

  localparam int unsigned CODE_W = 5;

  localparam logic [CODE_W-1:0] EC_INT  = 5'd0;
  localparam logic [CODE_W-1:0] EC_MOD  = 5'd1;
  localparam logic [CODE_W-1:0] EC_TLBL = 5'd2;
  localparam logic [CODE_W-1:0] EC_TLBS = 5'd3;
  localparam logic [CODE_W-1:0] EC_ADEL = 5'd4;
  localparam logic [CODE_W-1:0] EC_ADES = 5'd5;

  localparam int unsigned ST_EXL    = 1;
  localparam int unsigned ST_ERL    = 2;
  localparam int unsigned ST_KSU_LO = 3;
  localparam int unsigned ST_KSU_HI = 4;
  localparam int unsigned ST_NMI    = 19;
  localparam int unsigned ST_SR     = 20;
  localparam int unsigned ST_BEV    = 22;

  localparam int unsigned CA_EC_LO  = 2;
  localparam int unsigned CA_EC_HI  = CA_EC_LO + CODE_W - 1;
  localparam int unsigned CA_IV     = 23;
  localparam int unsigned CA_BD     = 31;

endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_entry_pkg::*;
(
  input  logic [2:0]        kind,
  input  logic [1:0]        fault,
  input  logic              store,
  input  logic [CODE_W-1:0] code_in,
  input  logic              exl,
  input  logic              iv,
  output logic [CODE_W-1:0] code,
  output off_sel_e          off_sel,
  output logic              rst_class,
  output logic              is_xlat,
  output logic              soft_rst,
  output logic              is_nmi
);

  always_comb begin
    rst_class = (kind == EK_HRST) || (kind == EK_SRST) || (kind == EK_NMI);
    is_xlat   = (kind == EK_XLAT);
    soft_rst  = (kind == EK_SRST);
    is_nmi    = (kind == EK_NMI);
  end

  always_comb begin
    code = code_in;
    if (kind == EK_INT) begin
      code = EC_INT;
    end else if (kind == EK_XLAT) begin
      unique case (fault)
        XF_BADADDR:            code = store ? EC_ADES : EC_ADEL;
        XF_NOMATCH, XF_INVALID: code = store ? EC_TLBS : EC_TLBL;
        default:               code = EC_MOD;
      endcase
    end
  end

  always_comb begin
    off_sel = OFF_GENERAL;
    if ((kind == EK_XLAT) && (fault == XF_NOMATCH) && !exl) begin
      off_sel = OFF_REFILL;
    end else if ((kind == EK_INT) && iv) begin
      off_sel = OFF_IRQ;
    end
  end

endmodule

// File: rtl/exc_vector.sv
module exc_vector
  import exc_entry_pkg::*;
#(
  parameter int unsigned          VA_W      = 32,
  parameter int unsigned          EBASE_LSB = 10,
  parameter logic [VA_W-1:0]      BOOT_BASE = 32'hBFC0_0200,
  parameter logic [VA_W-1:0]      RESET_VEC = 32'hBFC0_0000,
  parameter logic [VA_W-1:0]      OFF_GEN   = 32'h0000_0180,
  parameter logic [VA_W-1:0]      OFF_INTR  = 32'h0000_0200
) (
  input  logic            bev,
  input  logic [VA_W-1:0] ebase,
  input  off_sel_e        off_sel,
  input  logic            rst_class,
  output logic [VA_W-1:0] vector
);

  logic [VA_W-1:0] base;
  logic [VA_W-1:0] offset;

  always_comb begin
    base = ebase;
    base[EBASE_LSB-1:0] = '0;
    if (bev) base = BOOT_BASE;
  end

  always_comb begin
    unique case (off_sel)
      OFF_REFILL: offset = '0;
      OFF_IRQ:    offset = OFF_INTR;
      default:    offset = OFF_GEN;
    endcase
  end

  always_comb begin
    vector = rst_class ? RESET_VEC : (base + offset);
  end

endmodule

// File: rtl/exc_fault_rec.sv
module exc_fault_rec #(
  parameter int unsigned VA_W    = 32,
  parameter int unsigned ASID_W  = 8,
  parameter int unsigned VPN2_LO = 13,
  parameter int unsigned CTX_LO  = 4
) (
  input  logic [VA_W-1:0]   addr,
  input  logic [ASID_W-1:0] asid,
  input  logic [VA_W-1:0]   ctx_in,
  output logic [VA_W-1:0]   bva,
  output logic [VA_W-1:0]   ctx,
  output logic [VA_W-1:0]   ehi
);

  localparam int unsigned VPN2_W = VA_W - VPN2_LO;
  localparam int unsigned CTX_HI = CTX_LO + VPN2_W - 1;

  always_comb begin
    bva = addr;
    ctx = ctx_in;
    ctx[CTX_HI:CTX_LO] = addr[VA_W-1:VPN2_LO];
    ehi = {addr[VA_W-1:VPN2_LO], {VPN2_LO{1'b0}}};
    ehi[ASID_W-1:0] = asid;
  end

endmodule

// File: rtl/exc_entry.sv
module exc_entry
  import exc_entry_pkg::*;
#(
  parameter int unsigned     VA_W      = 32,
  parameter int unsigned     ASID_W    = 8,
  parameter int unsigned     VPN2_LO   = 13,
  parameter int unsigned     CTX_LO    = 4,
  parameter int unsigned     INSN_B    = 4,
  parameter logic [31:0]     BOOT_BASE = 32'hBFC0_0200,
  parameter logic [31:0]     RESET_VEC = 32'hBFC0_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_valid,
  input  logic [2:0]        exc_kind,
  input  logic [4:0]        exc_code_in,
  input  logic [1:0]        xlat_fault,
  input  logic              xlat_store,
  input  logic              in_delay_slot,
  input  logic [31:0]       cur_pc,
  input  logic [31:0]       fault_addr,
  input  logic [31:0]       status_in,
  input  logic [31:0]       cause_in,
  input  logic [31:0]       context_in,
  input  logic [31:0]       ebase_in,
  input  logic [31:0]       entryhi_in,
  output logic              redirect_vld,
  output logic [31:0]       redirect_pc,
  output logic [31:0]       status_q,
  output logic [31:0]       cause_q,
  output logic [31:0]       epc_q,
  output logic              epc_wr,
  output logic [31:0]       errorepc_q,
  output logic              errorepc_wr,
  output logic [31:0]       badvaddr_q,
  output logic [31:0]       context_q,
  output logic [31:0]       entryhi_q,
  output logic              fault_wr
);

  localparam logic [31:0] STEP_BACK = 32'(INSN_B);

  logic [CODE_W-1:0] code;
  off_sel_e          off_sel;
  logic              rst_class, is_xlat, soft_rst, is_nmi;
  logic              exl;
  logic [31:0]       ret_pc, vector;
  logic [31:0]       rec_bva, rec_ctx, rec_ehi;

  assign exl    = status_in[ST_EXL];
  assign ret_pc = in_delay_slot ? (cur_pc - STEP_BACK) : cur_pc;

  exc_classify u_classify (
    .kind      (exc_kind),
    .fault     (xlat_fault),
    .store     (xlat_store),
    .code_in   (exc_code_in),
    .exl       (exl),
    .iv        (cause_in[CA_IV]),
    .code      (code),
    .off_sel   (off_sel),
    .rst_class (rst_class),
    .is_xlat   (is_xlat),
    .soft_rst  (soft_rst),
    .is_nmi    (is_nmi)
  );

  exc_vector #(
    .VA_W      (VA_W),
    .BOOT_BASE (BOOT_BASE),
    .RESET_VEC (RESET_VEC)
  ) u_vector (
    .bev       (status_in[ST_BEV]),
    .ebase     (ebase_in),
    .off_sel   (off_sel),
    .rst_class (rst_class),
    .vector    (vector)
  );

  exc_fault_rec #(
    .VA_W    (VA_W),
    .ASID_W  (ASID_W),
    .VPN2_LO (VPN2_LO),
    .CTX_LO  (CTX_LO)
  ) u_fault_rec (
    .addr   (fault_addr),
    .asid   (entryhi_in[ASID_W-1:0]),
    .ctx_in (context_in),
    .bva    (rec_bva),
    .ctx    (rec_ctx),
    .ehi    (rec_ehi)
  );

  logic        vld_d, epcw_d, eepcw_d, fw_d;
  logic [31:0] rpc_d, st_d, ca_d, epc_d, eepc_d, bva_d, ctx_d, ehi_d;

  always_comb begin
    vld_d   = 1'b0;
    epcw_d  = 1'b0;
    eepcw_d = 1'b0;
    fw_d    = 1'b0;
    rpc_d   = redirect_pc;
    st_d    = status_q;
    ca_d    = cause_q;
    epc_d   = epc_q;
    eepc_d  = errorepc_q;
    bva_d   = badvaddr_q;
    ctx_d   = context_q;
    ehi_d   = entryhi_q;
    if (exc_valid) begin
      vld_d = 1'b1;
      rpc_d = vector;
      ca_d  = cause_in;
      st_d  = status_in;
      if (rst_class) begin
        st_d[ST_ERL] = 1'b1;
        st_d[ST_BEV] = 1'b1;
        if (soft_rst) st_d[ST_SR]  = 1'b1;
        if (is_nmi)   st_d[ST_NMI] = 1'b1;
        if (!exl)     ca_d[CA_BD]  = 1'b0;
        eepc_d  = ret_pc;
        eepcw_d = 1'b1;
      end else begin
        st_d[ST_EXL] = 1'b1;
        st_d[ST_KSU_HI:ST_KSU_LO] = '0;
        ca_d[CA_EC_HI:CA_EC_LO] = code;
        if (!exl) begin
          ca_d[CA_BD] = in_delay_slot;
          epc_d  = ret_pc;
          epcw_d = 1'b1;
        end
        if (is_xlat) begin
          bva_d = rec_bva;
          ctx_d = rec_ctx;
          ehi_d = rec_ehi;
          fw_d  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect_vld <= 1'b0;
      epc_wr       <= 1'b0;
      errorepc_wr  <= 1'b0;
      fault_wr     <= 1'b0;
      redirect_pc  <= '0;
      status_q     <= '0;
      cause_q      <= '0;
      epc_q        <= '0;
      errorepc_q   <= '0;
      badvaddr_q   <= '0;
      context_q    <= '0;
      entryhi_q    <= '0;
    end else begin
      redirect_vld <= vld_d;
      epc_wr       <= epcw_d;
      errorepc_wr  <= eepcw_d;
      fault_wr     <= fw_d;
      if (exc_valid) begin
        redirect_pc <= rpc_d;
        status_q    <= st_d;
        cause_q     <= ca_d;
        epc_q       <= epc_d;
        errorepc_q  <= eepc_d;
        badvaddr_q  <= bva_d;
        context_q   <= ctx_d;
        entryhi_q   <= ehi_d;
      end
    end
  end

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        exc_valid,
  input logic [2:0]  exc_kind,
  input logic [31:0] status_in,
  input logic [31:0] fault_addr,
  input logic        redirect_vld,
  input logic [31:0] redirect_pc,
  input logic [31:0] status_q,
  input logic        epc_wr,
  input logic        errorepc_wr,
  input logic [31:0] badvaddr_q,
  input logic        fault_wr
);

  p_commit_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_vld == $past(exc_valid));

  p_one_return_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({epc_wr, errorepc_wr}));

  p_fault_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_kind == 3'd4) |=> (fault_wr && badvaddr_q == $past(fault_addr)));

  p_exl_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_kind >= 3'd3) |=> (status_q[1] && status_q[4:3] == 2'b00));

  p_reset_vec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_kind <= 3'd2) |=> (redirect_pc == 32'hBFC0_0000 && status_q[2] && status_q[22]));

  p_epc_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_kind >= 3'd3 && !status_in[1]) |=> epc_wr);

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_valid |=> ($stable(redirect_pc) && $stable(status_q) && !fault_wr));

endmodule

bind exc_entry exc_entry_chk u_exc_entry_chk (.*);

// File: tb/exc_entry_bench.sv
module exc_entry_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        exc_valid;
  logic [2:0]  exc_kind;
  logic [4:0]  exc_code_in;
  logic [1:0]  xlat_fault;
  logic        xlat_store, in_delay_slot;
  logic [31:0] cur_pc, fault_addr, status_in, cause_in, context_in, ebase_in, entryhi_in;
  logic        redirect_vld, epc_wr, errorepc_wr, fault_wr;
  logic [31:0] redirect_pc, status_q, cause_q, epc_q, errorepc_q, badvaddr_q, context_q, entryhi_q;

  always #2.5 clk = ~clk;

  exc_entry u_exc_entry (.*);

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic        e_vld, e_epcw, e_eepcw, e_fw;
  logic [31:0] e_rpc, e_st, e_ca, e_epc, e_eepc, e_bva, e_ctx, e_ehi;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_code(input logic [2:0] k, input logic [1:0] f, input logic s, input logic [4:0] c);
    if (k == 3'd3) return 5'd0;
    if (k != 3'd4) return c;
    case (f)
      2'd0: return s ? 5'd5 : 5'd4;
      2'd1, 2'd2: return s ? 5'd3 : 5'd2;
      default: return 5'd1;
    endcase
  endfunction

  task automatic model();
    logic [31:0] ret, base, off;
    e_vld = exc_valid; e_epcw = 1'b0; e_eepcw = 1'b0; e_fw = 1'b0;
    if (!exc_valid) return;
    ret = in_delay_slot ? cur_pc - 32'd4 : cur_pc;
    e_st = status_in; e_ca = cause_in;
    if (exc_kind <= 3'd2) begin
      e_st = e_st | 32'h0040_0004;
      if (exc_kind == 3'd1) e_st[20] = 1'b1;
      if (exc_kind == 3'd2) e_st[19] = 1'b1;
      if (!status_in[1]) e_ca[31] = 1'b0;
      e_eepc = ret; e_eepcw = 1'b1; e_rpc = 32'hBFC0_0000;
    end else begin
      e_st[1] = 1'b1; e_st[4:3] = 2'b00;
      e_ca[6:2] = exp_code(exc_kind, xlat_fault, xlat_store, exc_code_in);
      if (!status_in[1]) begin e_ca[31] = in_delay_slot; e_epc = ret; e_epcw = 1'b1; end
      base = status_in[22] ? 32'hBFC0_0200 : (ebase_in & 32'hFFFF_FC00);
      if (exc_kind == 3'd4 && xlat_fault == 2'd1 && !status_in[1]) off = 32'h0;
      else if (exc_kind == 3'd3 && cause_in[23]) off = 32'h200;
      else off = 32'h180;
      e_rpc = base + off;
      if (exc_kind == 3'd4) begin
        e_fw = 1'b1; e_bva = fault_addr;
        e_ctx = (context_in & ~32'h007F_FFF0) | ({13'b0, fault_addr[31:13]} << 4);
        e_ehi = (fault_addr & 32'hFFFF_E000) | {24'b0, entryhi_in[7:0]};
      end
    end
  endtask

  task automatic check_all(input string ctx);
    chk("R12", {ctx, " redirect_vld"}, {31'b0, redirect_vld}, {31'b0, e_vld});
    chk("R7 R8 R10", {ctx, " redirect_pc"}, redirect_pc, e_rpc);
    chk("R6 R10 R11", {ctx, " status"}, status_q, e_st);
    chk("R1 R9 R5", {ctx, " cause"}, cause_q, e_ca);
    chk("R5", {ctx, " epc"}, epc_q, e_epc);
    chk("R5", {ctx, " epc_wr"}, {31'b0, epc_wr}, {31'b0, e_epcw});
    chk("R10", {ctx, " errorepc"}, errorepc_q, e_eepc);
    chk("R10", {ctx, " errorepc_wr"}, {31'b0, errorepc_wr}, {31'b0, e_eepcw});
    chk("R2", {ctx, " badvaddr"}, badvaddr_q, e_bva);
    chk("R3", {ctx, " context"}, context_q, e_ctx);
    chk("R4", {ctx, " entryhi"}, entryhi_q, e_ehi);
    chk("R2", {ctx, " fault_wr"}, {31'b0, fault_wr}, {31'b0, e_fw});
  endtask

  task automatic drive(input logic v, input logic [2:0] k, input logic [1:0] f, input logic s,
                       input logic ds, input logic [31:0] st, input logic [31:0] ca, input logic [31:0] pc,
                       input logic [31:0] fa);
    exc_valid = v; exc_kind = k; xlat_fault = f; xlat_store = s; in_delay_slot = ds;
    status_in = st; cause_in = ca; cur_pc = pc; fault_addr = fa;
    exc_code_in = 5'($urandom); context_in = $urandom; ebase_in = $urandom; entryhi_in = $urandom;
    model();
    @(negedge clk);
    check_all("step");
  endtask

  initial begin
    void'($urandom(32'h00C0_FFEE));
    rst_n = 1'b0;
    exc_valid = 1'b0; exc_kind = '0; exc_code_in = '0; xlat_fault = '0; xlat_store = 1'b0;
    in_delay_slot = 1'b0; cur_pc = '0; fault_addr = '0; status_in = '0; cause_in = '0;
    context_in = '0; ebase_in = '0; entryhi_in = '0;
    e_vld = 0; e_epcw = 0; e_eepcw = 0; e_fw = 0;
    e_rpc = 0; e_st = 0; e_ca = 0; e_epc = 0; e_eepc = 0; e_bva = 0; e_ctx = 0; e_ehi = 0;
    repeat (3) @(negedge clk);
    check_all("R13 reset");
    rst_n = 1'b1;
    @(negedge clk);
    // R8 refill offset: no-match, EXL clear, BEV set, load from delay slot
    drive(1, 3'd4, 2'd1, 0, 1, 32'h0040_0018, 32'h0000_0000, 32'h8000_1004, 32'h1234_5678);
    // R8 no-match with EXL set takes the general offset; R5 EPC held
    drive(1, 3'd4, 2'd1, 1, 0, 32'h0040_0002, 32'h8000_0000, 32'h8000_2000, 32'hFFFF_FFFF);
    // R8 interrupt with IV set, BEV clear
    drive(1, 3'd3, 2'd0, 0, 0, 32'h0000_0010, 32'h0080_0000, 32'h0040_0100, 32'h0);
    // R1 clean page written
    drive(1, 3'd4, 2'd3, 1, 0, 32'h0, 32'h0, 32'h0040_0200, 32'h0000_1FFF);
    // R11 soft reset and NMI, R10 from delay slot
    drive(1, 3'd1, 2'd0, 0, 1, 32'h0000_0002, 32'h8000_0000, 32'h0000_0100, 32'h0);
    drive(1, 3'd2, 2'd0, 0, 0, 32'h0000_0000, 32'h8000_007C, 32'h0000_0200, 32'h0);
    drive(1, 3'd0, 2'd0, 0, 0, 32'h0000_0000, 32'h0, 32'h0000_0300, 32'h0);
    // R12 idle cycles hold
    drive(0, 3'd4, 2'd1, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1, 32'h2);
    drive(0, 3'd0, 2'd0, 0, 0, 32'h0, 32'h0, 32'h3, 32'h4);
    for (int i = 0; i < 1500; i++) begin
      drive(($urandom % 4) != 0, 3'($urandom % 6), 2'($urandom), 1'($urandom), 1'($urandom),
            $urandom, $urandom, $urandom, $urandom);
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R12 watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule